// File: doc/BRIEF.md
# Quasi-Resonant Valley Mode Selector

This block decides which drain-voltage valley a quasi-resonant flyback controller switches in, based on a sampled feedback level expressed in millivolts. When the feedback level drops, the controller moves to later valleys. This lowers the switching frequency at lighter load. Once past the fourth valley, the block gives up valley counting and enters a frequency-foldback mode, in which the power stage adds dead time instead.

Each move toward a later valley has its own falling threshold. Each move back toward an earlier valley has a rising threshold placed 600 mV above the threshold that selected the current valley. The resulting hysteresis band keeps the controller locked in one valley while the feedback wanders inside that band. The block evaluates one feedback sample for each valid strobe and takes at most one step per sample. A large jump in feedback therefore walks through the modes one step at a time.

The block outputs a registered mode code and a one-cycle pulse that marks every mode change.

Top module: `vlm_valley_select`

## Requirements
- R1: Whenever reset is applied, the mode output returns to code 0 (valley 1) and the change pulse is low in the next cycle.
- R2: The mode code is 0, 1, 2 or 3 for valleys 1 to 4, and 4 for frequency foldback. No other value appears.
- R3: On a valid sample strictly below the falling threshold of the current mode, the mode code rises by one. The falling thresholds are 2500 mV for code 0, 2300 mV for code 1, 2100 mV for code 2 and 1900 mV for code 3.
- R4: On a valid sample strictly above the rising threshold of the current mode, the mode code falls by one. The rising thresholds are 2500 mV for code 4, 2700 mV for code 3, 2900 mV for code 2 and 3100 mV for code 1.
- R5: A sample equal to a threshold, or lying between the falling and rising thresholds of the current mode, leaves the mode unchanged.
- R6: One valid sample changes the mode code by at most one, however far the sample lies beyond a threshold.
- R7: While the valid strobe is low, the mode does not change, whatever the feedback input carries.
- R8: Code 0 never moves up toward an earlier valley. Code 4 never moves further down.
- R9: The change pulse is high for exactly the cycles in which the registered mode differs from its value one cycle earlier. It appears at the same clock edge as the new mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fb_mv | input | 12 | Sampled feedback level in millivolts |
| fb_valid | input | 1 | High for one cycle per new feedback sample |
| mode_o | output | 3 | Registered mode code (0..3 valleys 1..4, 4 foldback) |
| mode_chg_o | output | 1 | One-cycle pulse on each mode change |

## Verification
Two functions can fall in the same cycle: a fresh valid strobe that causes a new step, and the change pulse still raised by the step the previous strobe made. The bench provokes this with back-to-back strobes far below every threshold. The expected result is two single steps, not one double jump, with the pulse held high for two consecutive cycles and dropping as soon as a cycle passes without a step. Randomised sequences of strobes, some of them back to back, are judged cycle by cycle against a bench model of both threshold ladders.

// File: rtl/vlm_pkg.sv
// Package: shared mode encoding and default threshold set for the
// valley mode selector. Assumes feedback codes are unsigned millivolts.
package vlm_pkg;

    localparam int MODE_W = 3;

    // Mode codes: valleys 1..4 are 0..3, frequency foldback is 4.
    typedef enum logic [MODE_W-1:0] {
        MODE_V1 = 3'd0,
        MODE_V2 = 3'd1,
        MODE_V3 = 3'd2,
        MODE_V4 = 3'd3,
        MODE_FF = 3'd4
    } vlm_mode_e;

    // Default falling thresholds (mV) for leaving each valley downward.
    localparam int DEF_FALL_1 = 2500;
    localparam int DEF_FALL_2 = 2300;
    localparam int DEF_FALL_3 = 2100;
    localparam int DEF_FALL_4 = 1900;
    localparam int DEF_HYST   = 600;

endpackage

// File: rtl/vlm_ladder.sv
// Threshold ladder: for the present mode, returns the falling threshold
// that moves one step toward foldback and the rising threshold that moves
// one step back toward valley 1. Rising thresholds are derived as the
// falling threshold that selected the mode plus the hysteresis.
// Assumes thresholds plus hysteresis fit in CODE_W bits.
module vlm_ladder
    import vlm_pkg::*;
#(
    parameter int CODE_W  = 12,
    parameter int FALL_1  = DEF_FALL_1,
    parameter int FALL_2  = DEF_FALL_2,
    parameter int FALL_3  = DEF_FALL_3,
    parameter int FALL_4  = DEF_FALL_4,
    parameter int HYST_MV = DEF_HYST
) (
    input  vlm_mode_e          mode_i,
    output logic [CODE_W-1:0]  fall_thr_o,
    output logic [CODE_W-1:0]  rise_thr_o,
    output logic               fall_ok_o,
    output logic               rise_ok_o
);

    localparam int NRUNG = 4;

    logic [CODE_W-1:0] fall_tab [NRUNG];
    logic [CODE_W-1:0] rise_tab [NRUNG];

    // Build one rung per lockable valley: its exit-down and re-entry-up levels.
    for (genvar k = 0; k < NRUNG; k++) begin : g_rung
        localparam int FT = (k == 0) ? FALL_1 :
                            (k == 1) ? FALL_2 :
                            (k == 2) ? FALL_3 : FALL_4;
        assign fall_tab[k] = CODE_W'(FT);
        assign rise_tab[k] = CODE_W'(FT + HYST_MV);
    end

    // Select the thresholds that apply to the present mode.
    always_comb begin
        fall_thr_o = '0;
        rise_thr_o = '1;
        fall_ok_o  = 1'b0;
        rise_ok_o  = 1'b0;
        case (mode_i)
            MODE_V1: begin
                fall_thr_o = fall_tab[0];
                fall_ok_o  = 1'b1;
            end
            MODE_V2: begin
                fall_thr_o = fall_tab[1];
                rise_thr_o = rise_tab[0];
                fall_ok_o  = 1'b1;
                rise_ok_o  = 1'b1;
            end
            MODE_V3: begin
                fall_thr_o = fall_tab[2];
                rise_thr_o = rise_tab[1];
                fall_ok_o  = 1'b1;
                rise_ok_o  = 1'b1;
            end
            MODE_V4: begin
                fall_thr_o = fall_tab[3];
                rise_thr_o = rise_tab[2];
                fall_ok_o  = 1'b1;
                rise_ok_o  = 1'b1;
            end
            MODE_FF: begin
                rise_thr_o = rise_tab[3];
                rise_ok_o  = 1'b1;
            end
            default: begin
                fall_ok_o  = 1'b0;
                rise_ok_o  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/vlm_step.sv
// Step decision: compares a valid feedback sample with the ladder
// thresholds and returns the next mode, moving at most one step.
// Assumes the hysteresis keeps the two comparisons mutually exclusive;
// the falling step still wins if both were ever true.
module vlm_step
    import vlm_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic [CODE_W-1:0] fb_mv_i,
    input  logic              fb_valid_i,
    input  vlm_mode_e         mode_i,
    input  logic [CODE_W-1:0] fall_thr_i,
    input  logic [CODE_W-1:0] rise_thr_i,
    input  logic              fall_ok_i,
    input  logic              rise_ok_i,
    output vlm_mode_e         mode_nxt_o
);

    logic go_down;
    logic go_up;

    // Strict comparisons: a sample equal to a threshold holds the mode.
    always_comb begin
        go_down    = fb_valid_i && fall_ok_i && (fb_mv_i < fall_thr_i);
        go_up      = fb_valid_i && rise_ok_i && (fb_mv_i > rise_thr_i);
        mode_nxt_o = mode_i;
        if (go_down) begin
            mode_nxt_o = vlm_mode_e'(mode_i + 3'd1);
        end else if (go_up) begin
            mode_nxt_o = vlm_mode_e'(mode_i - 3'd1);
        end
    end

endmodule

// File: rtl/vlm_mode_reg.sv
// Mode register: holds the operating mode and raises a change pulse at
// the same edge that loads a different mode. Synchronous active-low reset.
module vlm_mode_reg
    import vlm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  vlm_mode_e mode_nxt_i,
    output vlm_mode_e mode_q_o,
    output logic      chg_q_o
);

    // Load the next mode and flag whether it differs from the held one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q_o <= MODE_V1;
            chg_q_o  <= 1'b0;
        end else begin
            mode_q_o <= mode_nxt_i;
            chg_q_o  <= (mode_nxt_i != mode_q_o);
        end
    end

endmodule

// File: rtl/vlm_valley_select.sv
// Top: valley lockout mode selector. Takes one step per valid feedback
// sample through valleys 1..4 and frequency foldback using a hysteretic
// threshold ladder. Assumes fb_mv is stable while fb_valid is high.
module vlm_valley_select
    import vlm_pkg::*;
#(
    parameter int CODE_W  = 12,
    parameter int FALL_1  = DEF_FALL_1,
    parameter int FALL_2  = DEF_FALL_2,
    parameter int FALL_3  = DEF_FALL_3,
    parameter int FALL_4  = DEF_FALL_4,
    parameter int HYST_MV = DEF_HYST
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] fb_mv,
    input  logic              fb_valid,
    output logic [MODE_W-1:0] mode_o,
    output logic              mode_chg_o
);

    vlm_mode_e         mode_q;
    vlm_mode_e         mode_nxt;
    logic [CODE_W-1:0] fall_thr;
    logic [CODE_W-1:0] rise_thr;
    logic              fall_ok;
    logic              rise_ok;
    logic              chg_q;

    vlm_ladder #(
        .CODE_W (CODE_W),
        .FALL_1 (FALL_1),
        .FALL_2 (FALL_2),
        .FALL_3 (FALL_3),
        .FALL_4 (FALL_4),
        .HYST_MV(HYST_MV)
    ) u_ladder (
        .mode_i    (mode_q),
        .fall_thr_o(fall_thr),
        .rise_thr_o(rise_thr),
        .fall_ok_o (fall_ok),
        .rise_ok_o (rise_ok)
    );

    vlm_step #(
        .CODE_W(CODE_W)
    ) u_step (
        .fb_mv_i   (fb_mv),
        .fb_valid_i(fb_valid),
        .mode_i    (mode_q),
        .fall_thr_i(fall_thr),
        .rise_thr_i(rise_thr),
        .fall_ok_i (fall_ok),
        .rise_ok_i (rise_ok),
        .mode_nxt_o(mode_nxt)
    );

    vlm_mode_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_nxt_i(mode_nxt),
        .mode_q_o  (mode_q),
        .chg_q_o   (chg_q)
    );

    // Drive the ports from the registered state.
    assign mode_o     = mode_q;
    assign mode_chg_o = chg_q;

endmodule

// File: rtl/vlm_valley_select_chk.sv
// Checker for the valley mode selector, bound to the top module.
// Observes ports only; threshold limits come from the package defaults.
module vlm_valley_select_chk
    import vlm_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] fb_mv,
    input logic              fb_valid,
    input logic [MODE_W-1:0] mode_o,
    input logic              mode_chg_o
);

    // R2: mode code stays within the five defined values.
    a_r2_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o <= 3'd4);

    // R7: no strobe, no mode movement.
    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !fb_valid |=> $stable(mode_o));

    // R6: a strobe moves the mode by at most one code.
    a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        fb_valid |=> (mode_o == $past(mode_o)) ||
                     (mode_o == $past(mode_o) + 3'd1) ||
                     ($past(mode_o) == mode_o + 3'd1));

    // R9: change pulse marks exactly the cycles where the mode moved.
    a_r9_pulse_match: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (mode_chg_o == (mode_o != $past(mode_o))));

    // R3: a sample above every rising level never moves toward foldback.
    a_r3_no_fall_high: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_valid && fb_mv > CODE_W'(DEF_FALL_1 + DEF_HYST))
            |=> mode_o <= $past(mode_o));

    // R4: a sample below every falling level never moves toward valley 1.
    a_r4_no_rise_low: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_valid && fb_mv < CODE_W'(DEF_FALL_4))
            |=> mode_o >= $past(mode_o));

endmodule

bind vlm_valley_select vlm_valley_select_chk #(.CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fb_mv     (fb_mv),
    .fb_valid  (fb_valid),
    .mode_o    (mode_o),
    .mode_chg_o(mode_chg_o)
);

// File: tb/vlm_valley_select_test.sv
// Bench for the valley mode selector: directed corners plus seeded random
// strobes, judged against a bench model of the two threshold ladders.
module vlm_valley_select_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] fb_mv;
    logic        fb_valid;
    logic [2:0]  mode_o;
    logic        mode_chg_o;

    int checks = 0;
    int errors = 0;
    int exp_m  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    vlm_valley_select uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .fb_mv     (fb_mv),
        .fb_valid  (fb_valid),
        .mode_o    (mode_o),
        .mode_chg_o(mode_chg_o)
    );

    // Model of R3/R4/R5/R8: next mode for one valid sample.
    function automatic int next_mode(int m, int c);
        case (m)
            0: return (c < 2500) ? 1 : 0;
            1: return (c < 2300) ? 2 : ((c > 3100) ? 0 : 1);
            2: return (c < 2100) ? 3 : ((c > 2900) ? 1 : 2);
            3: return (c < 1900) ? 4 : ((c > 2700) ? 2 : 3);
            default: return (c > 2500) ? 3 : 4;
        endcase
    endfunction

    task automatic check(string tag, int am, int em, int ac, int ec);
        checks++;
        if (am != em || ac != ec) begin
            errors++;
            $display("FAIL %s mode=%0d chg=%0d expected mode=%0d chg=%0d",
                     tag, am, ac, em, ec);
        end
    endtask

    // Apply one cycle of input (called at a negedge), sample at the next negedge.
    task automatic drive(bit v, int c, string tag);
        int em;
        fb_mv    = 12'(c);
        fb_valid = v;
        @(posedge clk);
        @(negedge clk);
        em = v ? next_mode(exp_m, c) : exp_m;
        check(tag, int'(mode_o), em, int'(mode_chg_o), (em != exp_m) ? 1 : 0);
        exp_m    = em;
        fb_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n    = 1'b0;
        fb_mv    = '0;
        fb_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", int'(mode_o), 0, int'(mode_chg_o), 0);
        rst_n = 1'b1;

        drive(1'b0, 100, "R7 idle low code");
        drive(1'b1, 2500, "R5 equal fall level");
        drive(1'b1, 2499, "R3 to valley 2");
        drive(1'b1, 2299, "R3 to valley 3");
        drive(1'b1, 2099, "R3 to valley 4");
        drive(1'b1, 1900, "R5 equal last fall");
        drive(1'b1, 1899, "R3 to foldback");
        drive(1'b1, 0, "R8 floor");
        drive(1'b1, 2500, "R5 equal rise from foldback");
        drive(1'b1, 2501, "R4 to valley 4");
        drive(1'b1, 2700, "R5 equal rise");
        drive(1'b1, 2701, "R4 to valley 3");
        drive(1'b1, 2901, "R4 to valley 2");
        drive(1'b1, 3101, "R4 to valley 1");
        drive(1'b1, 4095, "R8 ceiling");
        drive(1'b1, 100, "R6 first step of jump");
        drive(1'b1, 100, "R9 back to back step");
        drive(1'b0, 100, "R9 pulse drops");
        drive(1'b1, 2500, "R5 inside band");
        drive(1'b0, 4095, "R7 idle high code");
        drive(1'b1, 4095, "R6 single rise");

        // R1: reset mid-run returns to valley 1.
        drive(1'b1, 100, "R6 move off valley 1");
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 reset mid run", int'(mode_o), 0, int'(mode_chg_o), 0);
        exp_m = 0;
        rst_n = 1'b1;

        // R2 and R9 over random strobes, some back to back.
        for (int i = 0; i < 3000; i++) begin
            bit v;
            int c;
            v = ($urandom_range(0, 9) < 7);
            c = (i % 97 == 0) ? int'($urandom_range(0, 4095))
                              : int'($urandom_range(1500, 3400));
            drive(v, c, "R2 R9 random");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule